// File: doc/BRIEF.md
# Quadrature Step Decoder with Reversal Filter

This block turns the two channels of an incremental rotary encoder into step pulses at three resolutions and a direction flag. The channels enter through a short synchronizer. The block keeps the last sampled channel state and compares each new state against it. A move of one position along the two-bit Gray sequence is a valid transition. Every valid transition that is accepted yields a fine pulse. Medium and coarse pulses fire only when the new state is the configured reference state, or for the medium pulse also the state opposite it.

An optional filter removes the isolated back-steps that mechanical contacts tend to produce. While it is on, a single step against the current direction is swallowed. The direction changes only when a second step in the same new direction follows at once. A selection input chooses whether the combined step output follows the medium or the coarse pulse. This supports encoders whose detent count is twice their pulse count. A downstream counter consumes the step output and the direction.

Top module: `quad_decoder`

## Requirements
- R1: Each valid transition that is accepted produces a one-cycle pulse on `step_x4`. The pulse appears SYNC_STAGES+1 clock edges after the input change; the default is 3.
- R2: With the channel state written as {ch_a, ch_b}, the forward order is 00, 01, 11, 10, then back to 00. `dir` is 1 for forward and 0 for backward. It updates on the same edge as the pulse of the transition that sets it.
- R3: A change of both channels between two samples produces no pulse and leaves `dir` unchanged. The new state becomes the reference for the next comparison.
- R4: `step_x1` pulses only on an accepted transition whose new state equals `x1_ref`, written as {a,b}.
- R5: `step_x2` pulses on an accepted transition whose new state equals `x1_ref` or its bitwise complement.
- R6: With `debounce_en` high, a transition against `dir` produces no pulse and leaves `dir` unchanged. If the next valid transition is in that same new direction, it is accepted and flips `dir`.
- R7: With `debounce_en` high, a swallowed reversal followed by a step in the old direction arms nothing. That step is accepted, and a later single reversal is swallowed again.
- R8: With `debounce_en` low, every valid transition is accepted and `dir` takes its direction at once.
- R9: `step` equals `step_x2` when `x2_sel` or `x2_force` is high, and `step_x1` otherwise.
- R10: Reset clears all pulse outputs, sets `dir` to 1 and makes the stored channel state 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a | input | 1 | Encoder channel A |
| ch_b | input | 1 | Encoder channel B |
| x1_ref | input | 2 | Gray state {a,b} used as the coarse reference |
| debounce_en | input | 1 | Enables the reversal filter |
| x2_sel | input | 1 | Selects the medium pulse for `step` |
| x2_force | input | 1 | Forces the medium pulse for `step` |
| step_x4 | output | 1 | Pulse per accepted transition |
| step_x2 | output | 1 | Pulse twice per Gray cycle |
| step_x1 | output | 1 | Pulse once per Gray cycle |
| step | output | 1 | Selected step pulse for a counter |
| dir | output | 1 | Registered direction, 1 = forward |

## Verification
The bench first walks an illegal double change. A design that decoded it as a step would emit a pulse or flip the direction. It then drives a reversal that is confirmed and a reversal that is abandoned. A filter that flips at once, or that stays armed after the abandoned reversal, would show a wrong pulse or a wrong direction on those vectors. The reference state is moved to each of the four Gray values, which catches an X1/X2 decode tied to state 00 or counted from the wrong side. Forcing the medium pulse with the pin low, and a mid-run reset from backward motion, catch a dropped override and a wrong reset direction.

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_a,
  input  logic       ch_b,
  input  logic [1:0] x1_ref,
  input  logic       debounce_en,
  input  logic       x2_sel,
  input  logic       x2_force,
  output logic       step_x4,
  output logic       step_x2,
  output logic       step_x1,
  output logic       step,
  output logic       dir
);

  function automatic logic [1:0] gray_pos(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] s_cur, s_prev, dpos, rel;
  logic       valid, fwd, against, accept, pend_q;

  assign s_cur   = sync_q[SYNC_STAGES-1];
  assign dpos    = gray_pos(s_cur) - gray_pos(s_prev);
  assign valid   = (dpos == 2'd1) || (dpos == 2'd3);
  assign fwd     = (dpos == 2'd1);
  assign against = (fwd != dir);
  assign accept  = valid && (!debounce_en || !against || pend_q);
  assign rel     = gray_pos(s_cur) - gray_pos(x1_ref);
  assign step    = (x2_sel || x2_force) ? step_x2 : step_x1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 2'b00;
    end else begin
      sync_q[0] <= {ch_a, ch_b};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev  <= 2'b00;
      step_x4 <= 1'b0;
      step_x2 <= 1'b0;
      step_x1 <= 1'b0;
      dir     <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      s_prev  <= s_cur;
      step_x4 <= accept;
      step_x2 <= accept && !rel[0];
      step_x1 <= accept && (rel == 2'd0);
      if (accept) dir <= fwd;
      if (valid) pend_q <= debounce_en && against && !pend_q;
      else if (!debounce_en) pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/quad_decoder_chk.sv
module quad_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       debounce_en,
  input logic [1:0] s_cur,
  input logic [1:0] s_prev,
  input logic       valid,
  input logic       fwd,
  input logic       pend_q,
  input logic       dir,
  input logic       step_x4,
  input logic       step_x2,
  input logic       step_x1
);

  // R4
  x1_within_x2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_x1 |-> step_x2);

  // R5
  x2_within_x4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_x2 |-> step_x4);

  // R2
  dir_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir != $past(dir)) |-> step_x4);

  // R3
  double_change_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_cur ^ s_prev) == 2'b11) |=> (!step_x4 && $stable(dir)));

  // R6
  lone_reversal_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debounce_en && valid && (fwd != dir) && !pend_q) |=> (!step_x4 && $stable(dir)));

  // R8
  unfiltered_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!debounce_en && valid) |=> (step_x4 && (dir == $past(fwd))));

endmodule

bind quad_decoder quad_decoder_chk u_chk (
  .clk, .rst_n, .debounce_en, .s_cur, .s_prev, .valid, .fwd, .pend_q,
  .dir, .step_x4, .step_x2, .step_x1
);

// File: tb/tb_quad_decoder.sv
module tb_quad_decoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LAT = 3;
  localparam int  NV  = 25;

  // {ab[1:0], ref[1:0], dbn, x2sel, exp {x4,x2,x1,step,dir}}
  localparam logic [10:0] VEC [NV] = '{
    {2'b01, 2'b00, 1'b1, 1'b0, 5'b10001},
    {2'b11, 2'b00, 1'b1, 1'b0, 5'b11001},
    {2'b10, 2'b00, 1'b1, 1'b0, 5'b10001},
    {2'b00, 2'b00, 1'b1, 1'b0, 5'b11111},
    {2'b00, 2'b00, 1'b1, 1'b0, 5'b00001},
    {2'b11, 2'b00, 1'b1, 1'b0, 5'b00001},
    {2'b10, 2'b00, 1'b1, 1'b0, 5'b10001},
    {2'b11, 2'b00, 1'b1, 1'b0, 5'b00001},
    {2'b01, 2'b00, 1'b1, 1'b0, 5'b10000},
    {2'b00, 2'b00, 1'b1, 1'b0, 5'b11110},
    {2'b01, 2'b00, 1'b1, 1'b0, 5'b00000},
    {2'b00, 2'b00, 1'b1, 1'b0, 5'b11110},
    {2'b01, 2'b00, 1'b1, 1'b0, 5'b00000},
    {2'b11, 2'b00, 1'b1, 1'b1, 5'b11011},
    {2'b10, 2'b11, 1'b1, 1'b1, 5'b10001},
    {2'b00, 2'b11, 1'b1, 1'b1, 5'b11011},
    {2'b01, 2'b11, 1'b1, 1'b0, 5'b10001},
    {2'b11, 2'b11, 1'b1, 1'b0, 5'b11111},
    {2'b01, 2'b00, 1'b0, 1'b0, 5'b10000},
    {2'b11, 2'b00, 1'b0, 1'b0, 5'b11001},
    {2'b01, 2'b00, 1'b0, 1'b0, 5'b10000},
    {2'b00, 2'b00, 1'b0, 1'b0, 5'b11110},
    {2'b01, 2'b01, 1'b0, 1'b0, 5'b11111},
    {2'b11, 2'b10, 1'b0, 1'b0, 5'b10001},
    {2'b10, 2'b10, 1'b0, 1'b0, 5'b11111}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ch_a = 1'b0, ch_b = 1'b0, debounce_en = 1'b1, x2_sel = 1'b0, x2_force = 1'b0;
  logic [1:0] x1_ref = 2'b00;
  logic step_x4, step_x2, step_x1, step, dir;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_decoder dut (
    .clk, .rst_n, .ch_a, .ch_b, .x1_ref, .debounce_en, .x2_sel, .x2_force,
    .step_x4, .step_x2, .step_x1, .step, .dir
  );

  function automatic string req_of(input int i);
    if (i < 5)  return "R1 R2 R4";
    if (i == 5) return "R3";
    if (i < 10) return "R6";
    if (i < 13) return "R7";
    if (i < 18) return "R5 R9";
    if (i < 22) return "R8";
    return "R4";
  endfunction

  task automatic compare(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {step_x4, step_x2, step_x1, step, dir};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {x4,x2,x1,step,dir} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] ab, input logic [1:0] rf, input logic dbn,
                       input logic sel, input logic frc);
    @(negedge clk);
    {ch_a, ch_b} = ab;
    x1_ref = rf;
    debounce_en = dbn;
    x2_sel = sel;
    x2_force = frc;
    repeat (LAT) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    compare("R10", 5'b00001);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    compare("R10", 5'b00001);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][10:9], VEC[i][8:7], VEC[i][6], VEC[i][5], 1'b0);
      compare(req_of(i), VEC[i][4:0]);
    end

    // R9: force selects medium pulse with the pin low
    apply(2'b00, 2'b11, 1'b0, 1'b0, 1'b1);
    compare("R9", 5'b11011);
    // R8: backward move without filter, dir drops to 0
    apply(2'b10, 2'b11, 1'b0, 1'b0, 1'b0);
    compare("R8", 5'b10000);

    // R10: mid-run reset restores forward direction
    @(negedge clk);
    {ch_a, ch_b} = 2'b00;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    compare("R10", 5'b00001);
    @(negedge clk) rst_n = 1'b1;
    repeat (LAT + 1) @(posedge clk);
    #(CLK_PERIOD/4);
    compare("R10", 5'b00001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule